// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of ownership tokens shared by a left and a right access port. Software on either side uses them to agree on who may touch a shared resource. A port selects the semaphore bank with its own select line, picks a token with a few low address bits, and moves one data bit. Writing 0 asks for the token. Writing 1 gives it back. A read tells the port whether it currently holds the token.

Each token is free, held by the left port, or held by the right port. When both ports ask for the same free token in the same cycle, the left port gets it. A request that cannot be granted at once is remembered. The token then passes to the waiting port on the same clock edge that the holder releases it. Token state is registered. The read bit comes combinationally from the state at the start of the cycle, so a grant written in one cycle is first visible on a read in the next cycle.

Top module: `dual_sem_unit`

## Requirements
- R1: With a port's select low, its write enable and data have no effect on any token.
- R2: A port's read bit is 1 unless that port has select high, output enable high and write enable low in the same cycle.
- R3: During a read, the read bit is 0 when the addressing port holds the token and 1 otherwise. A free token reads 1 on both sides. Both ports never read 0 for the same token at the same time.
- R4: A write of data bit 0 to a free token gives that token to the writing port at the next clock edge.
- R5: A write of data bit 1 by the holder releases the token at the next clock edge. The token becomes free if no request from the other port is waiting.
- R6: The address picks one of eight tokens, and an access changes only the token it addresses.
- R7: When both ports write 0 to the same free token in one cycle, the left port receives it and the right port's request is kept waiting.
- R8: A write of data bit 1 from the port that does not hold the token leaves the token's holder unchanged.
- R9: A data-bit-0 write from the non-holder is kept. At the holder's release edge the token passes straight to that port instead of becoming free.
- R10: After reset all tokens are free and no request is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_addr | input | 3 | Left token address |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable |
| l_wbit | input | 1 | Left write data bit (0 request, 1 release) |
| l_rbit | output | 1 | Left read bit (0 means held by left) |
| r_sel | input | 1 | Right semaphore select |
| r_addr | input | 3 | Right token address |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable |
| r_wbit | input | 1 | Right write data bit (0 request, 1 release) |
| r_rbit | output | 1 | Right read bit (0 means held by right) |

## Verification
A holder field that is wrong shows up on the first read of that token from either port. The read bit is combinational from the registered state, so the error is visible one cycle after the write that caused it. A lost or false waiting request stays hidden until the holder releases. It then appears as a token that reads free instead of owned, or owned instead of free, in the cycle right after the release. A tie resolved the wrong way shows up the next cycle as the right port reading 0.

// File: rtl/semaphore_pkg.sv
package semaphore_pkg;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } token_t;

    localparam token_t TOKEN_RESET = '{owner: OWN_FREE, wait_l: 1'b0, wait_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NTOK = 8,
    parameter int AW   = $clog2(NTOK)
) (
    input  logic            sel,
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic            oe,
    input  logic            wbit,
    output logic [NTOK-1:0] req,
    output logic [NTOK-1:0] rel,
    output logic            rd_en
);
    logic wr;

    always_comb begin
        wr    = sel & we;
        rd_en = sel & oe & ~we;
    end

    for (genvar i = 0; i < NTOK; i++) begin : g_tok
        logic hit;
        always_comb begin
            hit    = (addr == AW'(i));
            req[i] = wr & hit & ~wbit;
            rel[i] = wr & hit & wbit;
        end
    end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
    import semaphore_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   l_req,
    input  logic   l_rel,
    input  logic   r_req,
    input  logic   r_rel,
    output owner_e owner
);
    token_t tok_d, tok_q;
    logic   want_l, want_r;

    always_comb begin
        tok_d  = tok_q;
        want_l = tok_q.wait_l | l_req;
        want_r = tok_q.wait_r | r_req;
        unique case (tok_q.owner)
            OWN_FREE: begin
                if (want_l) begin
                    tok_d.owner  = OWN_LEFT;
                    tok_d.wait_l = 1'b0;
                    tok_d.wait_r = want_r;
                end else if (want_r) begin
                    tok_d.owner  = OWN_RIGHT;
                    tok_d.wait_l = 1'b0;
                    tok_d.wait_r = 1'b0;
                end
            end
            OWN_LEFT: begin
                tok_d.wait_l = 1'b0;
                if (l_rel) begin
                    tok_d.owner  = want_r ? OWN_RIGHT : OWN_FREE;
                    tok_d.wait_r = 1'b0;
                end else begin
                    tok_d.wait_r = want_r;
                end
            end
            OWN_RIGHT: begin
                tok_d.wait_r = 1'b0;
                if (r_rel) begin
                    tok_d.owner  = want_l ? OWN_LEFT : OWN_FREE;
                    tok_d.wait_l = 1'b0;
                end else begin
                    tok_d.wait_l = want_l;
                end
            end
            default: tok_d = TOKEN_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= TOKEN_RESET;
        else        tok_q <= tok_d;
    end

    assign owner = tok_q.owner;
endmodule

// File: rtl/sem_read_select.sv
module sem_read_select
    import semaphore_pkg::*;
#(
    parameter int   NTOK = 8,
    parameter int   AW   = $clog2(NTOK),
    parameter logic SIDE_LEFT = 1'b1
) (
    input  logic [2*NTOK-1:0] own_flat,
    input  logic [AW-1:0]     addr,
    input  logic              rd_en,
    output logic              rbit
);
    localparam logic [1:0] MINE = SIDE_LEFT ? OWN_LEFT : OWN_RIGHT;
    logic [1:0] cur;

    always_comb begin
        cur = OWN_FREE;
        for (int i = 0; i < NTOK; i++) begin
            if (addr == AW'(i)) cur = own_flat[2*i +: 2];
        end
        rbit = rd_en ? (cur != MINE) : 1'b1;
    end
endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit
    import semaphore_pkg::*;
#(
    parameter int NTOK = 8,
    parameter int AW   = $clog2(NTOK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel,
    input  logic [AW-1:0] l_addr,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic          l_wbit,
    output logic          l_rbit,
    input  logic          r_sel,
    input  logic [AW-1:0] r_addr,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic          r_wbit,
    output logic          r_rbit
);
    logic [NTOK-1:0]   l_req, l_rel, r_req, r_rel;
    logic              l_rd, r_rd;
    logic [2*NTOK-1:0] own_flat;

    sem_port_decode #(.NTOK(NTOK), .AW(AW)) u_dec_l (
        .sel(l_sel), .addr(l_addr), .we(l_we), .oe(l_oe), .wbit(l_wbit),
        .req(l_req), .rel(l_rel), .rd_en(l_rd)
    );

    sem_port_decode #(.NTOK(NTOK), .AW(AW)) u_dec_r (
        .sel(r_sel), .addr(r_addr), .we(r_we), .oe(r_oe), .wbit(r_wbit),
        .req(r_req), .rel(r_rel), .rd_en(r_rd)
    );

    for (genvar i = 0; i < NTOK; i++) begin : g_cell
        owner_e own;
        sem_token_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[i]), .l_rel(l_rel[i]),
            .r_req(r_req[i]), .r_rel(r_rel[i]),
            .owner(own)
        );
        assign own_flat[2*i +: 2] = own;
    end

    sem_read_select #(.NTOK(NTOK), .AW(AW), .SIDE_LEFT(1'b1)) u_rd_l (
        .own_flat(own_flat), .addr(l_addr), .rd_en(l_rd), .rbit(l_rbit)
    );

    sem_read_select #(.NTOK(NTOK), .AW(AW), .SIDE_LEFT(1'b0)) u_rd_r (
        .own_flat(own_flat), .addr(r_addr), .rd_en(r_rd), .rbit(r_rbit)
    );
endmodule

// File: rtl/dual_sem_unit_chk.sv
module dual_sem_unit_chk #(
    parameter int NTOK = 8,
    parameter int AW   = $clog2(NTOK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel,
    input logic [AW-1:0]     l_addr,
    input logic              l_we,
    input logic              l_oe,
    input logic              l_wbit,
    input logic              l_rbit,
    input logic              r_sel,
    input logic [AW-1:0]     r_addr,
    input logic              r_we,
    input logic              r_oe,
    input logic              r_wbit,
    input logic              r_rbit,
    input logic [2*NTOK-1:0] own_flat
);
    localparam logic [1:0] C_FREE  = 2'b00;
    localparam logic [1:0] C_LEFT  = 2'b01;
    localparam logic [1:0] C_RIGHT = 2'b10;

    function automatic logic [1:0] own_at(input logic [2*NTOK-1:0] v, input logic [AW-1:0] a);
        logic [1:0] r;
        r = C_FREE;
        for (int i = 0; i < NTOK; i++) if (a == AW'(i)) r = v[2*i +: 2];
        return r;
    endfunction

    logic l_ask, r_ask, l_give, r_give;
    assign l_ask  = l_sel & l_we & ~l_wbit;
    assign r_ask  = r_sel & r_we & ~r_wbit;
    assign l_give = l_sel & l_we & l_wbit;
    assign r_give = r_sel & r_we & r_wbit;

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && l_oe && !l_we) |-> l_rbit);

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_oe && !l_we && r_sel && r_oe && !r_we && l_addr == r_addr) |-> (l_rbit || r_rbit));

    p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ask && own_at(own_flat, l_addr) == C_FREE) |=> own_at(own_flat, $past(l_addr)) == C_LEFT);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_give && own_at(own_flat, l_addr) == C_LEFT) |=> own_at(own_flat, $past(l_addr)) != C_LEFT);

    p_tie_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ask && r_ask && l_addr == r_addr && own_at(own_flat, l_addr) == C_FREE)
        |=> own_at(own_flat, $past(l_addr)) == C_LEFT);

    p_nonowner_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_give && own_at(own_flat, l_addr) == C_RIGHT && !(r_give && r_addr == l_addr))
        |=> own_at(own_flat, $past(l_addr)) == C_RIGHT);

    for (genvar i = 0; i < NTOK; i++) begin : g_legal
        p_legal_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
            own_flat[2*i +: 2] != 2'b11);
    end
endmodule

bind dual_sem_unit dual_sem_unit_chk #(.NTOK(NTOK), .AW(AW)) u_chk (.*);

// File: tb/dual_sem_unit_bench.sv
module dual_sem_unit_bench;
    localparam int NT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       l_sel = 0, l_we = 0, l_oe = 0, l_wbit = 0;
    logic [2:0] l_addr = 0;
    logic       r_sel = 0, r_we = 0, r_oe = 0, r_wbit = 0;
    logic [2:0] r_addr = 0;
    logic       l_rbit, r_rbit;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // model: 0 free, 1 left, 2 right
    int m_own [NT];
    bit m_wl  [NT];
    bit m_wr  [NT];

    always #5 clk = ~clk;

    dual_sem_unit u_dual_sem_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_addr(l_addr), .l_we(l_we), .l_oe(l_oe), .l_wbit(l_wbit), .l_rbit(l_rbit),
        .r_sel(r_sel), .r_addr(r_addr), .r_we(r_we), .r_oe(r_oe), .r_wbit(r_wbit), .r_rbit(r_rbit)
    );

    function automatic bit exp_rbit(input bit left, input bit sel, input bit oe, input bit we, input int a);
        if (!(sel && oe && !we)) return 1'b1;
        return (m_own[a] != (left ? 1 : 2));
    endfunction

    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            bit lq, lr, rq, rr, wl, wr;
            lq = l_sel && l_we && !l_wbit && l_addr == t;
            lr = l_sel && l_we &&  l_wbit && l_addr == t;
            rq = r_sel && r_we && !r_wbit && r_addr == t;
            rr = r_sel && r_we &&  r_wbit && r_addr == t;
            wl = m_wl[t] | lq;
            wr = m_wr[t] | rq;
            case (m_own[t])
                0: if (wl) begin m_own[t] = 1; m_wl[t] = 0; m_wr[t] = wr; end
                   else if (wr) begin m_own[t] = 2; m_wr[t] = 0; end
                1: begin m_wl[t] = 0;
                       if (lr) begin m_own[t] = wr ? 2 : 0; m_wr[t] = 0; end else m_wr[t] = wr; end
                default: begin m_wr[t] = 0;
                       if (rr) begin m_own[t] = wl ? 1 : 0; m_wl[t] = 0; end else m_wl[t] = wl; end
            endcase
        end
    endtask

    task automatic check_bit(input string tag, input string side, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s rbit got=%0b exp=%0b at %0t", tag, side, got, exp, $time);
        end
    endtask

    // inputs are applied just after a negedge; outputs checked mid low phase
    task automatic step(input string tag,
                        input bit ls, input int la, input bit lw, input bit lo, input bit lb,
                        input bit rs, input int ra, input bit rw, input bit ro, input bit rb);
        l_sel = ls; l_addr = 3'(la); l_we = lw; l_oe = lo; l_wbit = lb;
        r_sel = rs; r_addr = 3'(ra); r_we = rw; r_oe = ro; r_wbit = rb;
        #2;
        check_bit(tag, "left",  l_rbit, exp_rbit(1, ls, lo, lw, la));
        check_bit(tag, "right", r_rbit, exp_rbit(0, rs, ro, rw, ra));
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input int la, input int ra);
        step(tag, 1, la, 0, 1, 0, 1, ra, 0, 1, 0);
    endtask

    initial begin
        #1500000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int t = 0; t < NT; t++) begin m_own[t] = 0; m_wl[t] = 0; m_wr[t] = 0; end
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: all free after reset
        for (int t = 0; t < NT; t++) rd("R10", t, t);
        // R4 grant, R3 readback
        step("R4", 1, 2, 1, 0, 0, 0, 0, 0, 0, 0);
        rd("R3", 2, 2);
        // R8: right release on left-held token ignored
        step("R8", 0, 0, 0, 0, 0, 1, 2, 1, 0, 1);
        rd("R8", 2, 2);
        // R9: right request queued, handed over on left release
        step("R9", 0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
        rd("R9", 2, 2);
        step("R5", 1, 2, 1, 0, 1, 0, 0, 0, 0, 0);
        rd("R9", 2, 2);
        step("R5", 0, 0, 0, 0, 0, 1, 2, 1, 0, 1);
        rd("R5", 2, 2);
        // R7: tie on free token
        step("R7", 1, 5, 1, 0, 0, 1, 5, 1, 0, 0);
        rd("R7", 5, 5);
        step("R7", 1, 5, 1, 0, 1, 0, 0, 0, 0, 0);
        rd("R7", 5, 5);
        step("R7", 0, 0, 0, 0, 0, 1, 5, 1, 0, 1);
        // R1: write without select has no effect
        step("R1", 0, 1, 1, 0, 0, 0, 1, 1, 0, 0);
        rd("R1", 1, 1);
        // R2: output enable low reads 1
        step("R2", 1, 3, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 3, 0, 0, 0, 1, 3, 0, 0, 0);
        step("R2", 0, 3, 0, 1, 0, 0, 3, 0, 1, 0);
        rd("R2", 3, 3);
        // R6: tokens independent
        step("R6", 0, 0, 0, 0, 0, 1, 4, 1, 0, 0);
        rd("R6", 4, 4);
        rd("R6", 3, 3);
        rd("R6", 3, 4);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit ls, lw, lo, lb, rs, rw, ro, rb;
            int la, ra;
            ls = ($urandom % 4) != 0; lw = $urandom % 2; lo = $urandom % 2; lb = $urandom % 2;
            rs = ($urandom % 4) != 0; rw = $urandom % 2; ro = $urandom % 2; rb = $urandom % 2;
            la = ($urandom % 3 == 0) ? int'($urandom % 8) : int'($urandom % 3);
            ra = ($urandom % 3 == 0) ? int'($urandom % 8) : int'($urandom % 3);
            step((ls && lo && !lw) ? "R3" : "R2", ls, la, lw, lo, lb, rs, ra, rw, ro, rb);
        end
        for (int t = 0; t < NT; t++) rd("R3", t, t);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule